// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a single-clock synchronous SRAM. The bus can switch between reads and writes on any cycle without an idle cycle in between. Every control input and the address are captured on the rising clock edge. A read presents its word combinationally during the cycle after the edge that captured its address (flow-through). A write takes its data one active edge later than its address. The captured data sits in an input register until the next active edge, when it is committed to the array. Any read that hits that held word gets it through a per-lane bypass.

The word is split into byte lanes, each with its own active-low write enable. A cycle-start input chooses between two cases:

- **New operation:** the address, the kind of operation and the chip selects are taken from the current inputs.
- **Burst continuation:** the previous operation carries on at the next address of a four-beat sequence, in either linear or interleaved order.

An active-low clock enable freezes the model. Three chip selects must all agree for a new operation to take place. A sleep input silences the output bus and cancels any write still in flight.

The read bus is modelled as a data vector plus a drive flag. A low drive flag stands for a high-impedance bus.

Top module: `turnless_sram`

## Requirements
- R1: At an active edge with `advLdN` low, sleep low and all three chip selects asserted (`ceN`=0, `ce2`=1, `ce2N`=0), `rwN`=1 starts a read and `rwN`=0 starts a write.
- R2: Read data appears on `rdData`, with `rdDrive` high, throughout the cycle after the edge that registered the read. `rdDrive` follows `oeN` combinationally: it is high only while `oeN` is low.
- R3: Write data is sampled from `dataIn` at the first active edge after the write's control edge. Lane `l` is bits `[l*LANE_W +: LANE_W]` and is updated only if `byteWeN[l]` was 0 at the control edge. If all lanes are disabled, the write changes nothing.
- R4: A read returns the most recent data, lane by lane, including a write whose data was sampled at the same edge that registered the read.
- R5: With `advLdN` high at an active edge, the previous operation continues. The upper address bits are held. With `linearBurst`=1 the low two bits become (start+n) mod 4; with `linearBurst`=0 they become start XOR n, where n is the beat number. A write beat takes its lane enables at its own edge.
- R6: An edge with `clkEnN` high changes no state. The output holds, and `dataIn` is not sampled at that edge.
- R7: A new-operation edge without all three selects asserted is a deselect. It produces no drive and no write, and continuation edges after it stay deselected.
- R8: While `sleep` is high, `rdDrive` is low. An active edge with `sleep` high deselects the model and drops the pending write, including data due at that edge. Array contents are kept.
- R9: After reset `rdDrive` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of control state |
| clkEnN | input | 1 | Active-low clock enable; high stalls |
| advLdN | input | 1 | Low starts a new operation, high continues a burst |
| rwN | input | 1 | High read, low write (new operations only) |
| ceN | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce2N | input | 1 | Active-low chip select |
| byteWeN | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address |
| linearBurst | input | 1 | 1 linear, 0 interleaved burst order |
| dataIn | input | LANES*LANE_W | Write data |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Standby request |
| rdData | output | LANES*LANE_W | Read data, zero when not driven |
| rdDrive | output | 1 | High when the read bus is driven |

## Verification
The bench builds the model with the default 16-word array, two 9-bit lanes and the 2-bit burst counter. At that size the following are all covered by sweeps:

- every address;
- every lane-enable combination, including the all-disabled abort;
- every burst start offset in both orders.

A reference memory in the bench is updated at the edge where write data is due. This lets back-to-back write-then-read pairs to one address, randomly stalled traffic, deselects on each select input and a write cancelled by sleep all be compared word by word.

// File: rtl/tsram_pkg.sv
package tsram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cycKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic stepGo;     // clock edge is active (not stalled)
    logic sleepGo;    // standby at this edge
    logic captureGo;  // current beat is a write with at least one lane
    logic readOn;     // current beat is a selected read
  } dpStrobe_t;

endpackage

// File: rtl/tsram_ctrl.sv
module tsram_ctrl
  import tsram_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LANES      = 2,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEnN,
  input  logic              advLdN,
  input  logic              rwN,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic [LANES-1:0]  byteWeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linearBurst,
  input  logic              sleep,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LANES-1:0]  curLanes
);

  localparam int HIGH_W = ADDR_W - BURST_BITS;

  cycKind_e              cycKind;
  logic [ADDR_W-1:0]     baseAddr;
  logic [BURST_BITS-1:0] beatCnt;
  logic [LANES-1:0]      laneEn;
  logic                  selNow;
  logic [BURST_BITS-1:0] lowBits;

  assign selNow = !ceN && ce2 && !ce2N;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycKind  <= CYC_IDLE;
      baseAddr <= '0;
      beatCnt  <= '0;
      laneEn   <= '0;
    end else if (!clkEnN) begin
      if (sleep) begin
        cycKind <= CYC_IDLE;
      end else if (!advLdN) begin
        cycKind  <= selNow ? (rwN ? CYC_READ : CYC_WRITE) : CYC_IDLE;
        baseAddr <= addr;
        beatCnt  <= '0;
        laneEn   <= ~byteWeN;
      end else begin
        beatCnt <= beatCnt + 1'b1;
        if (cycKind == CYC_WRITE) laneEn <= ~byteWeN;
      end
    end
  end

  assign lowBits = linearBurst ? (baseAddr[BURST_BITS-1:0] + beatCnt)
                               : (baseAddr[BURST_BITS-1:0] ^ beatCnt);

  generate
    if (HIGH_W > 0) begin : g_upper
      assign curAddr = {baseAddr[ADDR_W-1:BURST_BITS], lowBits};
    end else begin : g_flat
      assign curAddr = lowBits;
    end
  endgenerate

  assign curLanes         = laneEn;
  assign strobe.stepGo    = !clkEnN;
  assign strobe.sleepGo   = sleep;
  assign strobe.captureGo = (cycKind == CYC_WRITE) && (|laneEn);
  assign strobe.readOn    = (cycKind == CYC_READ);

endmodule

// File: rtl/tsram_datapath.sv
module tsram_datapath
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [LANES-1:0]        curLanes,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] pendData;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendLanes;
  logic              pendValid;
  logic              commitNow;
  logic [WORD_W-1:0] memWord;
  logic [WORD_W-1:0] mergedWord;

  assign commitNow = strobe.stepGo && !strobe.sleepGo && pendValid;

  // input data register: holds the latest sampled write until next edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pendData  <= '0;
      pendAddr  <= '0;
      pendLanes <= '0;
    end else if (strobe.stepGo) begin
      if (strobe.sleepGo) begin
        pendValid <= 1'b0;
      end else if (strobe.captureGo) begin
        pendValid <= 1'b1;
        pendData  <= dataIn;
        pendAddr  <= curAddr;
        pendLanes <= curLanes;
      end else begin
        pendValid <= 1'b0;
      end
    end
  end

  // deferred array commit, lane by lane
  always_ff @(posedge clk) begin
    if (commitNow) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendLanes[l]) memArr[pendAddr][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign memWord = memArr[curAddr];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
      logic hitLane;
      assign hitLane = pendValid && (pendAddr == curAddr) && pendLanes[g];
      assign mergedWord[g*LANE_W +: LANE_W] = hitLane ? pendData[g*LANE_W +: LANE_W]
                                                      : memWord[g*LANE_W +: LANE_W];
    end
  endgenerate

  assign rdDrive = strobe.readOn && !oeN && !sleep;
  assign rdData  = rdDrive ? mergedWord : '0;

endmodule

// File: rtl/turnless_sram.sv
module turnless_sram
  import tsram_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LANES      = 2,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clkEnN,
  input  logic                    advLdN,
  input  logic                    rwN,
  input  logic                    ceN,
  input  logic                    ce2,
  input  logic                    ce2N,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    linearBurst,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] curAddr;
  logic [LANES-1:0]  curLanes;

  tsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .advLdN(advLdN), .rwN(rwN),
    .ceN(ceN), .ce2(ce2), .ce2N(ce2N), .byteWeN(byteWeN), .addr(addr),
    .linearBurst(linearBurst), .sleep(sleep),
    .strobe(strobe), .curAddr(curAddr), .curLanes(curLanes)
  );

  tsram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .curAddr(curAddr), .curLanes(curLanes),
    .dataIn(dataIn), .oeN(oeN), .sleep(sleep), .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: rtl/tsram_checker.sv
module tsram_checker #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEnN,
  input logic              advLdN,
  input logic              rwN,
  input logic              ceN,
  input logic              ce2,
  input logic              ce2N,
  input logic              oeN,
  input logic              sleep,
  input logic              rdDrive,
  input logic [ADDR_W-1:0] curAddr,
  input logic [LANES-1:0]  curLanes
);

  logic selIn;
  assign selIn = !ceN && ce2 && !ce2N;

  // R7
  desel_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !advLdN && !sleep && !selIn) |=> !rdDrive);

  // R1
  read_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !advLdN && !sleep && selIn && rwN) |=> (rdDrive == (!oeN && !sleep)));

  // R1
  write_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !advLdN && !sleep && selIn && !rwN) |=> !rdDrive);

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !rdDrive);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> ($stable(curAddr) && $stable(curLanes)));

endmodule

bind turnless_sram tsram_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .clkEnN(clkEnN), .advLdN(advLdN), .rwN(rwN),
  .ceN(ceN), .ce2(ce2), .ce2N(ce2N), .oeN(oeN), .sleep(sleep),
  .rdDrive(rdDrive), .curAddr(curAddr), .curLanes(curLanes)
);

// File: tb/tb_turnless_sram.sv
`timescale 1ns/1ps
module tb_turnless_sram;

  localparam int AW = 4;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int W  = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkEnN = 1'b0, advLdN = 1'b0, rwN = 1'b1;
  logic ceN = 1'b1, ce2 = 1'b1, ce2N = 1'b0;
  logic [LN-1:0] byteWeN = '1;
  logic [AW-1:0] addr = '0;
  logic linearBurst = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic oeN = 1'b0, sleep = 1'b0;
  logic [W-1:0] rdData;
  logic rdDrive;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  turnless_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .advLdN(advLdN), .rwN(rwN),
    .ceN(ceN), .ce2(ce2), .ce2N(ce2N), .byteWeN(byteWeN), .addr(addr),
    .linearBurst(linearBurst), .dataIn(dataIn), .oeN(oeN), .sleep(sleep),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  // requirement-level reference model
  logic [W-1:0] refMem [DEPTH];
  int mKind = 0;            // 0 idle, 1 read, 2 write
  logic [AW-1:0] mBase = '0;
  int mCnt = 0;
  logic [LN-1:0] mLanes = '0;
  logic [W-1:0] expData = '0;
  logic [W-1:0] carryDin = '0;

  function automatic logic [AW-1:0] beatAddr(logic [AW-1:0] b, int n, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'((int'(b[1:0]) + n) % 4) : (b[1:0] ^ 2'(n));
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOut(string tag);
    logic expDrive;
    expDrive = (mKind == 1) && !oeN && !sleep;
    check(tag, {rdDrive, rdData}, {expDrive, expDrive ? expData : {W{1'b0}}});
  endtask

  // one clock: drive at negedge, model the edge, sample at next negedge
  task automatic tick(string tag, bit stall, bit adv, bit rw, logic [AW-1:0] a,
                      logic [LN-1:0] weN, logic [W-1:0] din);
    clkEnN = stall; advLdN = adv; rwN = rw; addr = a; byteWeN = weN; dataIn = din;
    if (!stall) begin
      if (sleep) mKind = 0;
      else begin
        if (mKind == 2) begin
          for (int l = 0; l < LN; l++)
            if (mLanes[l]) refMem[beatAddr(mBase, mCnt, linearBurst)][l*LW +: LW] = din[l*LW +: LW];
        end
        if (!adv) begin
          mKind  = (!ceN && ce2 && !ce2N) ? (rw ? 1 : 2) : 0;
          mBase  = a; mCnt = 0; mLanes = ~weN;
        end else if (mKind != 0) begin
          mCnt++;
          if (mKind == 2) mLanes = ~weN;
        end
      end
      if (mKind == 1) expData = refMem[beatAddr(mBase, mCnt, linearBurst)];
    end
    @(posedge clk);
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic opWrite(string tag, logic [AW-1:0] a, logic [LN-1:0] weN, logic [W-1:0] d);
    tick(tag, 0, 0, 0, a, weN, carryDin);
    carryDin = d;
  endtask

  task automatic opRead(string tag, logic [AW-1:0] a);
    tick(tag, 0, 0, 1, a, '1, carryDin);
  endtask

  task automatic opCont(string tag, logic [LN-1:0] weN, logic [W-1:0] d);
    tick(tag, 0, 1, 1, '0, weN, carryDin);
    carryDin = d;
  endtask

  task automatic opNop(string tag);
    logic sv;
    sv = ceN; ceN = 1'b1;
    tick(tag, 0, 0, 1, '0, '1, carryDin);
    ceN = sv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 reset", {rdDrive, rdData}, {1'b1'(0), {W{1'b0}}});
    ceN = 1'b0;

    // R3 R1: fill every address, then read back
    for (int a = 0; a < DEPTH; a++) opWrite("R3 fill", AW'(a), '0, W'(a * 37 + 5));
    for (int a = 0; a < DEPTH; a++) opRead("R1 readback", AW'(a));

    // R4: write immediately followed by read, same address
    for (int a = 0; a < DEPTH; a++) begin
      opWrite("R4 wr", AW'(a), '0, W'(a * 1021 + 77));
      opRead("R4 fwd", AW'(a));
      opRead("R4 again", AW'(a));
    end
    // R3 R4: every lane-enable pattern incl. abort, read-write-read
    for (int w = 0; w < 4; w++) begin
      opRead("R4 pre", AW'(w + 4));
      opWrite("R3 lanes", AW'(w + 4), LN'(w), W'(18'h2AAAA + w));
      opRead("R4 merge", AW'(w + 4));
    end

    // R2: output enable gating
    opRead("R2 read", 4'd3);
    oeN = 1'b1; #1;
    check("R2 oe off", {rdDrive, rdData}, {1'b1'(0), {W{1'b0}}});
    oeN = 1'b0; #1;
    check("R2 oe on", {rdDrive, rdData}, {1'b1'(1), expData});
    @(negedge clk);

    // R6: random traffic with random stalls and output enable
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 7);
      oeN = ($urandom_range(0, 7) == 0);
      if (r < 2) tick("R6 stall", 1, $urandom_range(0, 1), $urandom_range(0, 1),
                      AW'($urandom), LN'($urandom), W'($urandom));
      else if (r < 5) opWrite("R6 wr", AW'($urandom), LN'($urandom), W'($urandom));
      else opRead("R6 rd", AW'($urandom));
    end
    oeN = 1'b0;

    // R5: bursts, both orders, all start offsets
    for (int lin = 0; lin < 2; lin++) begin
      linearBurst = lin[0];
      for (int s = 0; s < 4; s++) begin
        opWrite("R5 bw", AW'(8 + s), '0, W'(lin * 64 + s * 8));
        for (int n = 1; n < 4; n++) opCont("R5 bwc", LN'(n == 2 ? 1 : 0), W'(lin * 64 + s * 8 + n + 1000));
        opRead("R5 br", AW'(8 + s));
        for (int n = 1; n < 4; n++) opCont("R5 brc", '1, '0);
      end
    end
    linearBurst = 1'b1;

    // R7: each chip select alone blocks the cycle
    for (int c = 0; c < 3; c++) begin
      if (c == 0) ceN = 1'b1; else if (c == 1) ce2 = 1'b0; else ce2N = 1'b1;
      opWrite("R7 desel wr", 4'd1, '0, 18'h1F0F0);
      opCont("R7 desel cont", '0, 18'h0F0F0);
      opRead("R7 desel rd", 4'd1);
      ceN = 1'b0; ce2 = 1'b1; ce2N = 1'b0;
      opRead("R7 unchanged", 4'd1);
    end

    // R8: sleep drops a write whose data is due, keeps array
    opWrite("R8 wr", 4'd2, '0, 18'h3C3C3);
    sleep = 1'b1;
    opNop("R8 sleep edge");
    sleep = 1'b0;
    opRead("R8 kept", 4'd2);
    sleep = 1'b1; #1;
    check("R8 quiet", {rdDrive, rdData}, {1'b1'(0), {W{1'b0}}});
    sleep = 1'b0; #1;
    check("R8 wake", {rdDrive, rdData}, {1'b1'(1), expData});
    @(negedge clk);
    opNop("R8 idle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule